// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the hazard-tracking core of a small single-issue pipeline whose results may complete out of order. A decoded instruction names an operation class, one destination register and two source registers. The controller decides, every cycle, whether that instruction can enter a functional unit. It also decides when each occupied unit may read its operands and when each finished unit may commit its result to the register file.

One central table holds a status record for each unit. The record keeps the unit's destination, its two sources, the units that will produce those sources and two source-ready flags. A per-register ownership array records which unit, if any, will write each register. Arithmetic is not modelled. Each unit counts down a fixed execute latency after it reads its operands, then raises a request for write-back.

Each instruction passes through four steps in strict order: issue, operand read, execute and write-back. The controller reports each step as a pulse on its own output. Checking those pulse cycles against a hand-built timing table therefore verifies the whole hazard policy.

Top module: `sb_issue_ctrl`

## Requirements
- R1: An instruction presented with `instr_valid` is accepted in the same cycle (`issue_ok`=1, `stall`=0) when its unit is idle and no unit owns its destination register. Otherwise `stall`=1 and `issue_ok`=0, and the instruction is held at the input until it is accepted.
- R2: Operation class 0 selects the adder unit, class 1 the multiplier and class 2 the divider. A unit holds at most one instruction. A second instruction for a busy unit is first accepted in the cycle after that unit's write-back.
- R3: An instruction whose destination is owned by an unfinished instruction (write-after-write) stalls until the cycle after that owner's write-back.
- R4: A unit reads operands (`rd_grant` bit) only when both sources are ready. The earliest read is the cycle after issue. A source produced by another unit becomes ready in the cycle after that unit's write-back. A source whose producer writes back in the issue cycle counts as ready at issue.
- R5: `ex_done` for a unit pulses exactly L cycles after its operand read, where L is 1 for the adder, 3 for the multiplier and 6 for the divider.
- R6: A finished unit's write-back is held while another unit has a ready source, not yet read, that names the finished unit's destination (write-after-read).
- R7: Write-back is granted no earlier than the cycle after `ex_done`. `wb_grant` is one-hot or zero, `wb_reg` carries the written register, and among simultaneous requesters the lowest unit index wins.
- R8: After reset every unit is idle, no register is owned, and all grants are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Decoded instruction present |
| instr_fu | input | 2 | Operation class (unit index) |
| instr_dst | input | 3 | Destination register |
| instr_src1 | input | 3 | First source register |
| instr_src2 | input | 3 | Second source register |
| issue_ok | output | 1 | Instruction accepted this cycle |
| stall | output | 1 | Instruction present but held |
| rd_grant | output | 3 | Per-unit operand-read grant |
| ex_done | output | 3 | Per-unit execute-complete pulse |
| wb_grant | output | 3 | Per-unit write-back grant |
| wb_reg | output | 3 | Register written on write-back |

## Verification
Short instruction sequences each isolate one hazard. They cover a lone add, a multiply feeding an add (RAW), two back-to-back multiplies (structural), a divide and an add to the same register (WAW), and a pending reader whose source is overwritten by a faster unit (WAR). An add and a multiply that finish together exercise the arbitration. A consumer issued in the very cycle its producer writes back exercises the same-cycle readiness path. Every pulse is compared with an expected cycle, unit and register. Each sequence therefore separates a correctly gated stage from one that fires too early, too late or never.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OPS  = 2'd1,
    PH_EXEC = 2'd2,
    PH_WB   = 2'd3
  } sb_phase_e;
endpackage

// File: rtl/sb_result_stat.sv
module sb_result_stat #(
  parameter int NUM_REGS = 8,
  parameter int RW       = 3,
  parameter int FW       = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         set_en,
  input  logic [RW-1:0]                set_reg,
  input  logic [FW-1:0]                set_fu,
  input  logic                         clr_en,
  input  logic [RW-1:0]                clr_reg,
  output logic [NUM_REGS-1:0]          pend,
  output logic [NUM_REGS-1:0][FW-1:0]  owner
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      owner <= '0;
    end else begin
      if (clr_en) pend[clr_reg] <= 1'b0;
      if (set_en) begin
        pend[set_reg]  <= 1'b1;
        owner[set_reg] <= set_fu;
      end
    end
  end
endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot
  import sb_pkg::*;
#(
  parameter int RW  = 3,
  parameter int FW  = 2,
  parameter int LAT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_en,
  input  logic [RW-1:0] iss_fi,
  input  logic [RW-1:0] iss_fj,
  input  logic [RW-1:0] iss_fk,
  input  logic [FW-1:0] iss_qj,
  input  logic [FW-1:0] iss_qk,
  input  logic          iss_rj,
  input  logic          iss_rk,
  input  logic          wb_any,
  input  logic [FW-1:0] wb_idx,
  input  logic          wb_mine,
  input  logic          war_hold,
  output logic          busy,
  output logic [RW-1:0] fi,
  output logic [RW-1:0] fj,
  output logic [RW-1:0] fk,
  output logic          rj,
  output logic          rk,
  output logic          rd_go,
  output logic          done,
  output logic          wb_req
);
  localparam int TW = (LAT < 2) ? 1 : $clog2(LAT + 1);

  sb_phase_e     phase;
  logic [TW-1:0] timer;
  logic [FW-1:0] qj, qk;

  assign busy   = (phase != PH_IDLE);
  assign rd_go  = (phase == PH_OPS) && rj && rk;
  assign done   = (phase == PH_EXEC) && (timer == TW'(1));
  assign wb_req = (phase == PH_WB) && !war_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      timer <= '0;
      fi    <= '0;
      fj    <= '0;
      fk    <= '0;
      qj    <= '0;
      qk    <= '0;
      rj    <= 1'b0;
      rk    <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (iss_en) begin
          phase <= PH_OPS;
          fi    <= iss_fi;
          fj    <= iss_fj;
          fk    <= iss_fk;
          qj    <= iss_qj;
          qk    <= iss_qk;
          rj    <= iss_rj;
          rk    <= iss_rk;
        end
        PH_OPS: begin
          if (rd_go) begin
            phase <= PH_EXEC;
            timer <= TW'(LAT);
            rj    <= 1'b0;
            rk    <= 1'b0;
          end else begin
            if (wb_any && !rj && qj == wb_idx) rj <= 1'b1;
            if (wb_any && !rk && qk == wb_idx) rk <= 1'b1;
          end
        end
        PH_EXEC: begin
          if (timer == TW'(1)) phase <= PH_WB;
          else                 timer <= timer - TW'(1);
        end
        PH_WB: if (wb_mine) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sb_wb_pick.sv
module sb_wb_pick #(
  parameter int N  = 3,
  parameter int FW = 2
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic          any,
  output logic [FW-1:0] idx
);
  always_comb begin
    grant = '0;
    any   = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        any      = 1'b1;
        grant[i] = 1'b1;
        idx      = FW'(i);
      end
    end
  end
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl #(
  parameter int          NUM_REGS = 8,
  parameter int          NUM_FU   = 3,
  parameter int unsigned FU_LAT [NUM_FU] = '{1, 3, 6},
  parameter int          RW = $clog2(NUM_REGS),
  parameter int          FW = $clog2(NUM_FU)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [FW-1:0]     instr_fu,
  input  logic [RW-1:0]     instr_dst,
  input  logic [RW-1:0]     instr_src1,
  input  logic [RW-1:0]     instr_src2,
  output logic              issue_ok,
  output logic              stall,
  output logic [NUM_FU-1:0] rd_grant,
  output logic [NUM_FU-1:0] ex_done,
  output logic [NUM_FU-1:0] wb_grant,
  output logic [RW-1:0]     wb_reg
);
  logic [NUM_REGS-1:0]         pend;
  logic [NUM_REGS-1:0][FW-1:0] owner;
  logic [NUM_FU-1:0]           busy, rj, rk, wb_req, war_hold;
  logic [NUM_FU-1:0][RW-1:0]   fi, fj, fk;
  logic                        wb_any;
  logic [FW-1:0]               wb_idx;
  logic                        fu_ok, unit_free;
  logic                        src1_rdy, src2_rdy;

  assign fu_ok = (32'(instr_fu) < NUM_FU);

  always_comb begin
    unit_free = 1'b0;
    for (int i = 0; i < NUM_FU; i++)
      if (instr_fu == FW'(i)) unit_free = !busy[i];
  end

  assign issue_ok = instr_valid && fu_ok && unit_free && !pend[instr_dst];
  assign stall    = instr_valid && !issue_ok;

  // a source is ready if nobody owns it, or its owner commits this cycle
  assign src1_rdy = !pend[instr_src1] || (wb_any && owner[instr_src1] == wb_idx);
  assign src2_rdy = !pend[instr_src2] || (wb_any && owner[instr_src2] == wb_idx);

  always_comb begin
    for (int f = 0; f < NUM_FU; f++) begin
      war_hold[f] = 1'b0;
      for (int k = 0; k < NUM_FU; k++) begin
        if (k != f && busy[k] &&
            ((rj[k] && fj[k] == fi[f]) || (rk[k] && fk[k] == fi[f])))
          war_hold[f] = 1'b1;
      end
    end
  end

  sb_result_stat #(.NUM_REGS(NUM_REGS), .RW(RW), .FW(FW)) rstat_i (
    .clk     (clk),
    .rst     (rst),
    .set_en  (issue_ok),
    .set_reg (instr_dst),
    .set_fu  (instr_fu),
    .clr_en  (wb_any),
    .clr_reg (wb_reg),
    .pend    (pend),
    .owner   (owner)
  );

  for (genvar g = 0; g < NUM_FU; g++) begin : g_slot
    sb_fu_slot #(.RW(RW), .FW(FW), .LAT(int'(FU_LAT[g]))) slot_i (
      .clk      (clk),
      .rst      (rst),
      .iss_en   (issue_ok && instr_fu == FW'(g)),
      .iss_fi   (instr_dst),
      .iss_fj   (instr_src1),
      .iss_fk   (instr_src2),
      .iss_qj   (owner[instr_src1]),
      .iss_qk   (owner[instr_src2]),
      .iss_rj   (src1_rdy),
      .iss_rk   (src2_rdy),
      .wb_any   (wb_any),
      .wb_idx   (wb_idx),
      .wb_mine  (wb_grant[g]),
      .war_hold (war_hold[g]),
      .busy     (busy[g]),
      .fi       (fi[g]),
      .fj       (fj[g]),
      .fk       (fk[g]),
      .rj       (rj[g]),
      .rk       (rk[g]),
      .rd_go    (rd_grant[g]),
      .done     (ex_done[g]),
      .wb_req   (wb_req[g])
    );
  end

  sb_wb_pick #(.N(NUM_FU), .FW(FW)) pick_i (
    .req   (wb_req),
    .grant (wb_grant),
    .any   (wb_any),
    .idx   (wb_idx)
  );

  always_comb begin
    wb_reg = '0;
    for (int i = 0; i < NUM_FU; i++)
      if (wb_grant[i]) wb_reg = fi[i];
  end
endmodule

// File: rtl/sb_issue_ctrl_chk.sv
module sb_issue_ctrl_chk #(
  parameter int          NUM_FU = 3,
  parameter int          FW     = 2,
  parameter int unsigned FU_LAT [NUM_FU] = '{1, 3, 6}
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic [FW-1:0]     instr_fu,
  input logic              issue_ok,
  input logic              stall,
  input logic [NUM_FU-1:0] rd_grant,
  input logic [NUM_FU-1:0] ex_done,
  input logic [NUM_FU-1:0] wb_grant
);
  logic [NUM_FU-1:0] occ;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else
      for (int f = 0; f < NUM_FU; f++) begin
        if (wb_grant[f]) occ[f] <= 1'b0;
        if (issue_ok && instr_fu == FW'(f)) occ[f] <= 1'b1;
      end
  end

  p_issue_stall_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(issue_ok && stall));

  p_stall_needs_valid_r1: assert property (@(posedge clk) disable iff (rst)
    stall |-> instr_valid);

  p_wb_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wb_grant));

  for (genvar g = 0; g < NUM_FU; g++) begin : g_chk
    logic [7:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (rd_grant[g]) cnt <= 8'd1;
      else if (ex_done[g])  cnt <= '0;
      else if (cnt != 0)    cnt <= cnt + 8'd1;
    end

    p_issue_free_unit_r2: assert property (@(posedge clk) disable iff (rst)
      (issue_ok && instr_fu == FW'(g)) |-> !occ[g]);

    p_read_occupied_r4: assert property (@(posedge clk) disable iff (rst)
      rd_grant[g] |-> (occ[g] && !wb_grant[g]));

    p_exec_latency_r5: assert property (@(posedge clk) disable iff (rst)
      ex_done[g] |-> (cnt == 8'(FU_LAT[g])));

    p_wb_after_done_r7: assert property (@(posedge clk) disable iff (rst)
      ex_done[g] |-> !wb_grant[g]);

    p_wb_occupied_r7: assert property (@(posedge clk) disable iff (rst)
      wb_grant[g] |-> occ[g]);
  end
endmodule

bind sb_issue_ctrl sb_issue_ctrl_chk #(
  .NUM_FU (NUM_FU),
  .FW     (FW),
  .FU_LAT (FU_LAT)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr_fu    (instr_fu),
  .issue_ok    (issue_ok),
  .stall       (stall),
  .rd_grant    (rd_grant),
  .ex_done     (ex_done),
  .wb_grant    (wb_grant)
);

// File: tb/sb_issue_ctrl_tb_top.sv
module sb_issue_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       instr_valid = 1'b0;
  logic [1:0] instr_fu = '0;
  logic [2:0] instr_dst = '0, instr_src1 = '0, instr_src2 = '0;
  logic       issue_ok, stall;
  logic [2:0] rd_grant, ex_done, wb_grant, wb_reg;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int t0    = 0;

  typedef struct {
    int    cyc;
    int    kind;   // 0 issue, 1 read, 2 done, 3 write-back
    int    fu;
    int    rg;
    string req;
  } ev_t;

  ev_t exp_q[$];

  sb_issue_ctrl dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_fu(instr_fu),
    .instr_dst(instr_dst), .instr_src1(instr_src1), .instr_src2(instr_src2),
    .issue_ok(issue_ok), .stall(stall), .rd_grant(rd_grant),
    .ex_done(ex_done), .wb_grant(wb_grant), .wb_reg(wb_reg)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic expect_ev(int off, int kind, int fu, int rg, string req);
    ev_t e;
    e.cyc = t0 + off; e.kind = kind; e.fu = fu; e.rg = rg; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic observe(int kind, int fu, int rg);
    ev_t e;
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected event: got cyc=%0d kind=%0d fu=%0d reg=%0d, expected none",
               cyc - t0, kind, fu, rg);
    end else begin
      e = exp_q.pop_front();
      if (e.cyc != cyc || e.kind != kind || e.fu != fu || e.rg != rg) begin
        n_bad++;
        $display("FAIL %s: got cyc=%0d kind=%0d fu=%0d reg=%0d, expected cyc=%0d kind=%0d fu=%0d reg=%0d",
                 e.req, cyc - t0, kind, fu, rg, e.cyc - t0, e.kind, e.fu, e.rg);
      end
    end
  endtask

  // monitor: pops expected pulses in cycle, kind, unit order
  always @(negedge clk) begin
    if (!rst) begin
      if (issue_ok) observe(0, int'(instr_fu), int'(instr_dst));
      for (int f = 0; f < 3; f++) if (rd_grant[f]) observe(1, f, 0);
      for (int f = 0; f < 3; f++) if (ex_done[f])  observe(2, f, 0);
      for (int f = 0; f < 3; f++) if (wb_grant[f]) observe(3, f, int'(wb_reg));
    end
  end

  task automatic check(bit ok, string req, int got, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // driver: holds the instruction until accepted, checking the stall flag (R1)
  task automatic present(int fu, int dst, int s1, int s2);
    bit taken = 0;
    instr_valid = 1'b1; instr_fu = 2'(fu);
    instr_dst = 3'(dst); instr_src1 = 3'(s1); instr_src2 = 3'(s2);
    while (!taken) begin
      @(negedge clk);
      taken = issue_ok;
      check(stall == !taken, "R1", int'(stall), int'(!taken));
      @(posedge clk); #1;
    end
    instr_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic drain(string req);
    idle(14);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 5000) begin
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected completion", wd);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(rd_grant == 0 && ex_done == 0 && wb_grant == 0, "R8",
          int'({rd_grant, ex_done, wb_grant}), 0);
    check(!issue_ok && !stall, "R8", int'({issue_ok, stall}), 0);
    @(posedge clk); #1;

    // lone add: latency 1
    t0 = cyc;
    expect_ev(0, 0, 0, 1, "R1"); expect_ev(1, 1, 0, 0, "R4");
    expect_ev(2, 2, 0, 0, "R5"); expect_ev(3, 3, 0, 1, "R7");
    present(0, 1, 2, 3);
    drain("R5");

    // RAW: mul r1 feeds add r4
    t0 = cyc;
    expect_ev(0, 0, 1, 1, "R1");
    expect_ev(1, 0, 0, 4, "R1"); expect_ev(1, 1, 1, 0, "R4");
    expect_ev(4, 2, 1, 0, "R5"); expect_ev(5, 3, 1, 1, "R7");
    expect_ev(6, 1, 0, 0, "R4"); expect_ev(7, 2, 0, 0, "R5");
    expect_ev(8, 3, 0, 4, "R7");
    present(1, 1, 2, 3); present(0, 4, 1, 5);
    drain("R4");

    // structural: two multiplies
    t0 = cyc;
    expect_ev(0, 0, 1, 1, "R1"); expect_ev(1, 1, 1, 0, "R4");
    expect_ev(4, 2, 1, 0, "R5"); expect_ev(5, 3, 1, 1, "R7");
    expect_ev(6, 0, 1, 2, "R2"); expect_ev(7, 1, 1, 0, "R4");
    expect_ev(10, 2, 1, 0, "R5"); expect_ev(11, 3, 1, 2, "R7");
    present(1, 1, 2, 3); present(1, 2, 4, 5);
    drain("R2");

    // WAW: div r3 then add r3
    t0 = cyc;
    expect_ev(0, 0, 2, 3, "R1"); expect_ev(1, 1, 2, 0, "R4");
    expect_ev(7, 2, 2, 0, "R5"); expect_ev(8, 3, 2, 3, "R7");
    expect_ev(9, 0, 0, 3, "R3"); expect_ev(10, 1, 0, 0, "R4");
    expect_ev(11, 2, 0, 0, "R5"); expect_ev(12, 3, 0, 3, "R7");
    present(2, 3, 1, 2); present(0, 3, 4, 5);
    drain("R3");

    // WAR: add waits on div for r1 while mul overwrites r6 that add still reads
    t0 = cyc;
    expect_ev(0, 0, 2, 1, "R1");
    expect_ev(1, 0, 0, 4, "R1"); expect_ev(1, 1, 2, 0, "R4");
    expect_ev(2, 0, 1, 6, "R1"); expect_ev(3, 1, 1, 0, "R4");
    expect_ev(6, 2, 1, 0, "R5"); expect_ev(7, 2, 2, 0, "R5");
    expect_ev(8, 3, 2, 1, "R7"); expect_ev(9, 1, 0, 0, "R4");
    expect_ev(10, 2, 0, 0, "R5"); expect_ev(10, 3, 1, 6, "R6");
    expect_ev(11, 3, 0, 4, "R7");
    present(2, 1, 2, 3); present(0, 4, 1, 6); present(1, 6, 2, 3);
    drain("R6");

    // simultaneous requests: add beats mul
    t0 = cyc;
    expect_ev(0, 0, 1, 1, "R1"); expect_ev(1, 1, 1, 0, "R4");
    expect_ev(2, 0, 0, 2, "R1"); expect_ev(3, 1, 0, 0, "R4");
    expect_ev(4, 2, 0, 0, "R5"); expect_ev(4, 2, 1, 0, "R5");
    expect_ev(5, 3, 0, 2, "R7"); expect_ev(6, 3, 1, 1, "R7");
    present(1, 1, 3, 4); idle(1); present(0, 2, 5, 6);
    drain("R7");

    // consumer issued in the producer's write-back cycle
    t0 = cyc;
    expect_ev(0, 0, 2, 5, "R1"); expect_ev(1, 1, 2, 0, "R4");
    expect_ev(7, 2, 2, 0, "R5");
    expect_ev(8, 0, 0, 6, "R4"); expect_ev(8, 3, 2, 5, "R7");
    expect_ev(9, 1, 0, 0, "R4"); expect_ev(10, 2, 0, 0, "R5");
    expect_ev(11, 3, 0, 6, "R7");
    present(2, 5, 1, 2); idle(7); present(0, 6, 5, 1);
    drain("R4");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule